// File: doc/BRIEF.md
# Decimalised PIN Offset Unit

This unit turns a 64-bit block cipher output into a four-digit customer PIN. It also performs the reverse step: it works out the offset that makes a chosen PIN valid. The input block is read as sixteen hexadecimal digits, with the most significant digit first. Each digit is folded into a decimal digit by taking it modulo ten. The four leading folded digits form the natural PIN.

In PIN mode, a four-digit BCD offset is added to the natural PIN one digit at a time, modulo ten, with no carry between digits. In offset mode, the four-digit BCD value is taken to be the desired PIN, and the unit returns, for each digit, the desired digit minus the natural digit, modulo ten. A code input that contains a digit above nine is rejected and flagged as an error.

Requests arrive on a valid/ready handshake. All results are registered and appear together with a single-cycle valid pulse.

Top module: `pin_offset_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` and `out_error` are 0 and `out_decimal`, `out_natural` and `out_result` are all zero.
- R2: Each 4-bit digit of `out_decimal`, at the same bit position as in `in_block`, equals the input digit modulo ten. So 0–9 are unchanged, and A, B, C, D, E, F become 0, 1, 2, 3, 4, 5. Example: A2CE126C69AEC82D gives 0224126269042823.
- R3: `out_natural` equals the four leading digits of the folded block, that is bits 63:48 of `out_decimal`.
- R4: With `in_mode`=0 (PIN mode), each BCD digit of `out_result` is (natural digit + code digit) mod 10, and no carry passes between digits. Example: 0224 with offset 6565 gives 6789, and 9999 with 0001 gives 9990.
- R5: With `in_mode`=1 (offset mode), each BCD digit of `out_result` is (code digit − natural digit) mod 10. Example: desired 6789 with natural 0224 gives 6565.
- R6: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` and `in_ready` are both 1, and 0 in every other cycle.
- R7: If any 4-bit digit of `in_code` is greater than 9, the result cycle shows `out_error`=1 and `out_result`=0. Otherwise it shows `out_error`=0.
- R8: `in_ready` is 0 while `rst` is high and 1 otherwise.
- R9: Outside a result cycle, `out_decimal`, `out_natural`, `out_result` and `out_error` keep the values of the last accepted request. Inputs presented without `in_valid` have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_mode | input | 1 | 0: compute PIN from offset, 1: compute offset from desired PIN |
| in_block | input | 64 | Cipher output, 16 hex digits, most significant first |
| in_code | input | 16 | BCD offset (mode 0) or desired PIN (mode 1) |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_error | output | 1 | Code input held a non-decimal digit |
| out_decimal | output | 64 | Folded block, 16 BCD digits |
| out_natural | output | 16 | Natural PIN, 4 BCD digits |
| out_result | output | 16 | PIN or offset, 4 BCD digits |

## Verification
Every result register is loaded on the clock edge that completes the handshake. So `out_valid`, `out_error`, the folded block, the natural PIN and the result are all due one cycle after acceptance, and `out_valid` falls again one cycle after that. The bench drives a request at a falling edge, removes `in_valid` at the next falling edge and samples every output at that moment, which is the single result cycle. It then samples again one falling edge later to confirm that the pulse has ended and the data is held. Checks on holding are made after input changes presented without `in_valid`, before the next request is accepted.

// File: rtl/pin_pkg.sv
package pin_pkg;

    typedef logic [3:0] digit_t;

    typedef enum logic {
        MODE_PIN    = 1'b0,
        MODE_OFFSET = 1'b1
    } mode_e;

    // Fold one hex digit into 0..9 (value modulo ten)
    function automatic digit_t fold_digit(input digit_t h);
        digit_t r;
        if (h >= 4'd10) r = h - 4'd10;
        else            r = h;
        return r;
    endfunction

    function automatic digit_t add_mod10(input digit_t a, input digit_t b);
        logic [4:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 5'd10) s = s - 5'd10;
        return s[3:0];
    endfunction

    function automatic digit_t sub_mod10(input digit_t a, input digit_t b);
        logic [4:0] s;
        s = {1'b0, a} + 5'd10 - {1'b0, b};
        if (s >= 5'd10) s = s - 5'd10;
        return s[3:0];
    endfunction

    function automatic logic digit_is_bcd(input digit_t d);
        return d <= 4'd9;
    endfunction

endpackage

// File: rtl/pin_hex_fold.sv
module pin_hex_fold
    import pin_pkg::*;
#(
    parameter int DIGITS = 16
) (
    input  logic [4*DIGITS-1:0] hex_in,
    output logic [4*DIGITS-1:0] dec_out
);
    for (genvar i = 0; i < DIGITS; i++) begin : g_fold
        assign dec_out[4*i +: 4] = fold_digit(hex_in[4*i +: 4]);
    end
endmodule

// File: rtl/pin_digit_combine.sv
module pin_digit_combine
    import pin_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] natural_in,
    input  logic [4*DIGITS-1:0] code_in,
    input  mode_e               mode,
    output logic [4*DIGITS-1:0] result_out,
    output logic                code_bad
);
    logic [DIGITS-1:0] bad_digit;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        digit_t nat_d;
        digit_t code_d;
        assign nat_d        = natural_in[4*i +: 4];
        assign code_d       = code_in[4*i +: 4];
        assign bad_digit[i] = !digit_is_bcd(code_d);
        always_comb begin
            if (mode == MODE_OFFSET) result_out[4*i +: 4] = sub_mod10(code_d, nat_d);
            else                     result_out[4*i +: 4] = add_mod10(nat_d, code_d);
        end
    end

    assign code_bad = |bad_digit;
endmodule

// File: rtl/pin_offset_unit.sv
module pin_offset_unit
    import pin_pkg::*;
#(
    parameter int BLOCK_DIGITS = 16,
    parameter int PIN_DIGITS   = 4,
    localparam int BLOCK_W     = 4 * BLOCK_DIGITS,
    localparam int CODE_W      = 4 * PIN_DIGITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_mode,
    input  logic [BLOCK_W-1:0] in_block,
    input  logic [CODE_W-1:0]  in_code,
    output logic               out_valid,
    output logic               out_error,
    output logic [BLOCK_W-1:0] out_decimal,
    output logic [CODE_W-1:0]  out_natural,
    output logic [CODE_W-1:0]  out_result
);
    logic               fire;
    logic [BLOCK_W-1:0] dec_w;
    logic [CODE_W-1:0]  nat_w;
    logic [CODE_W-1:0]  res_w;
    logic               bad_w;

    assign in_ready = !rst;
    assign fire     = in_valid && in_ready;

    pin_hex_fold #(.DIGITS(BLOCK_DIGITS)) u_fold (
        .hex_in (in_block),
        .dec_out(dec_w)
    );

    assign nat_w = dec_w[BLOCK_W-1 -: CODE_W];

    pin_digit_combine #(.DIGITS(PIN_DIGITS)) u_combine (
        .natural_in(nat_w),
        .code_in   (in_code),
        .mode      (mode_e'(in_mode)),
        .result_out(res_w),
        .code_bad  (bad_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_error   <= 1'b0;
            out_decimal <= '0;
            out_natural <= '0;
            out_result  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_decimal <= dec_w;
                out_natural <= nat_w;
                out_error   <= bad_w;
                out_result  <= bad_w ? '0 : res_w;
            end
        end
    end

    function automatic logic all_bcd(input logic [BLOCK_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < BLOCK_DIGITS; i++) ok &= digit_is_bcd(v[4*i +: 4]);
        return ok;
    endfunction

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !out_valid);
    assert_error_zero_R7: assert property (@(posedge clk) disable iff (rst)
        out_error |-> (out_result == '0));
    assert_decimal_bcd_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> all_bcd(out_decimal));
    assert_natural_top_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_natural == out_decimal[BLOCK_W-1 -: CODE_W]));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(out_result) && $stable(out_decimal) && $stable(out_error)));
endmodule

// File: tb/pin_offset_unit_bench.sv
module pin_offset_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic        in_mode;
    logic [63:0] in_block;
    logic [15:0] in_code;
    logic        out_valid;
    logic        out_error;
    logic [63:0] out_decimal;
    logic [15:0] out_natural;
    logic [15:0] out_result;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pin_offset_unit u_pin_offset_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_block(in_block), .in_code(in_code),
        .out_valid(out_valid), .out_error(out_error), .out_decimal(out_decimal),
        .out_natural(out_natural), .out_result(out_result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference model
    function automatic logic [63:0] ref_fold(input logic [63:0] h);
        logic [63:0] r;
        for (int i = 0; i < 16; i++) r[4*i +: 4] = 4'(int'(h[4*i +: 4]) % 10);
        return r;
    endfunction

    function automatic logic [15:0] ref_combine(input logic [15:0] nat, input logic [15:0] code, input logic mode);
        logic [15:0] r;
        for (int i = 0; i < 4; i++) begin
            int n = int'(nat[4*i +: 4]);
            int c = int'(code[4*i +: 4]);
            r[4*i +: 4] = mode ? 4'((c - n + 10) % 10) : 4'((n + c) % 10);
        end
        return r;
    endfunction

    // Drive one request, sample in the result cycle
    task automatic run_op(input logic [63:0] blk, input logic [15:0] code, input logic mode);
        @(negedge clk);
        in_valid = 1'b1; in_block = blk; in_code = code; in_mode = mode;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_block = '0; in_code = '0;
        repeat (3) @(negedge clk);
        check("R8 ready low in reset", {63'd0, in_ready}, 64'd0);
        check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 error after reset", {63'd0, out_error}, 64'd0);
        check("R1 result after reset", {48'd0, out_result}, 64'd0);
        check("R1 decimal after reset", out_decimal, 64'd0);
        check("R8 ready after reset", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic test_example_pin();
        run_op(64'hA2CE126C69AEC82D, 16'h6565, 1'b0);
        check("R6 valid in result cycle", {63'd0, out_valid}, 64'd1);
        check("R2 decimal example", out_decimal, 64'h0224126269042823);
        check("R3 natural example", {48'd0, out_natural}, 64'h0224);
        check("R4 pin example", {48'd0, out_result}, 64'h6789);
        check("R7 no error", {63'd0, out_error}, 64'd0);
        @(negedge clk);
        check("R6 valid single pulse", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic test_all_hex();
        logic [63:0] blk = 64'h0123456789ABCDEF;
        run_op(blk, 16'h0000, 1'b0);
        check("R2 all hex digits", out_decimal, ref_fold(blk));
        check("R2 all hex literal", out_decimal, 64'h0123456789012345);
        blk = 64'hFEDCBA9876543210;
        run_op(blk, 16'h1357, 1'b0);
        check("R2 reversed digits", out_decimal, ref_fold(blk));
        check("R4 pin from F lead", {48'd0, out_result}, {48'd0, ref_combine(16'h5432, 16'h1357, 1'b0)});
    endtask

    task automatic test_no_carry();
        run_op(64'h9999000000000000, 16'h0001, 1'b0);
        check("R4 no carry 9999+0001", {48'd0, out_result}, 64'h9990);
        run_op(64'h9999000000000000, 16'h1111, 1'b0);
        check("R4 all wrap 9999+1111", {48'd0, out_result}, 64'h0000);
    endtask

    task automatic test_offset_mode();
        run_op(64'hA2CE126C69AEC82D, 16'h6789, 1'b1);
        check("R5 offset example", {48'd0, out_result}, 64'h6565);
        run_op(64'hFFFF000000000000, 16'h1234, 1'b1);
        check("R3 natural from F digits", {48'd0, out_natural}, 64'h5555);
        check("R5 offset borrow", {48'd0, out_result}, 64'h6789);
        run_op(64'h3B7E000011112222, 16'h0000, 1'b1);
        check("R5 offset to zero", {48'd0, out_result}, {48'd0, ref_combine(16'h3174, 16'h0000, 1'b1)});
    endtask

    task automatic test_error();
        run_op(64'hA2CE126C69AEC82D, 16'h6A65, 1'b0);
        check("R7 error flag", {63'd0, out_error}, 64'd1);
        check("R7 result zero", {48'd0, out_result}, 64'd0);
        check("R6 valid with error", {63'd0, out_valid}, 64'd1);
        run_op(64'h0000000000000000, 16'hF000, 1'b1);
        check("R7 error offset mode", {63'd0, out_error}, 64'd1);
        run_op(64'h1234000000000000, 16'h0999, 1'b0);
        check("R7 error clears", {63'd0, out_error}, 64'd0);
        check("R4 after error", {48'd0, out_result}, 64'h1123);
    endtask

    task automatic test_hold();
        run_op(64'h5555000000000000, 16'h2222, 1'b0);
        @(negedge clk);
        in_block = 64'hFFFFFFFFFFFFFFFF; in_code = 16'hAAAA; in_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 valid stays low", {63'd0, out_valid}, 64'd0);
        check("R9 result held", {48'd0, out_result}, 64'h7777);
        check("R9 decimal held", out_decimal, 64'h5555000000000000);
        check("R9 error held", {63'd0, out_error}, 64'd0);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        in_valid = 1'b1; in_block = 64'h1111000000000000; in_code = 16'h1111; in_mode = 1'b0;
        @(negedge clk);
        check("R6 first of pair", {48'd0, out_result}, 64'h2222);
        in_block = 64'h2222000000000000; in_code = 16'h0000; in_mode = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 second of pair valid", {63'd0, out_valid}, 64'd1);
        check("R5 second of pair", {48'd0, out_result}, 64'h8888);
        @(negedge clk);
        check("R6 pair ends", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        test_reset();
        test_example_pin();
        test_all_hex();
        test_no_carry();
        test_offset_mode();
        test_error();
        test_hold();
        test_back_to_back();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule